// File: doc/BRIEF.md
# RTC Register-Space I2C Target

This block is the serial front end of a real-time-clock macro. It answers as an I2C target at a fixed 7-bit address and gives a bus host byte access to a 64-byte space. Bytes 0x00 to 0x06 are the time-keeping counters, which belong to a neighbouring clock block. Byte 0x07 is a control byte, and bytes 0x08 to 0x3F are 56 bytes of general-purpose RAM. The control byte and the RAM are held inside this block.

A write transaction sends a one-byte register pointer and then any number of data bytes. A read transaction streams bytes out from the current pointer for as long as the host acknowledges. The pointer advances after every byte and wraps at the top of the space. Reads of the time bytes come from a seven-byte shadow copy. The copy is refreshed at every START and at every pointer-set write, so a multi-byte time read cannot tear across a counter rollover. Writes to the time bytes go out to the clock block as one-cycle strobes. A power-control input can refuse all bus access while the main supply is below its fail threshold.

SCL and SDA arrive as raw pins and pass through two-flop synchronisers in the system clock domain. That clock must be several times faster than SCL. SDA is driven only through an open-drain enable.

Top module: `rtc_i2c_regfile`

## Requirements
- R1: The address byte {7'b1101000, R/W} is acknowledged (SDA pulled low for the ninth clock) when `acc_en_i` is high. Every other 7-bit address receives no acknowledge.
- R2: In a write, the first byte after the address sets the register pointer from its bits [5:0]. Bits [7:6] are ignored, and the byte is acknowledged.
- R3: Each later write byte is acknowledged and stored at the pointer. The pointer then increments and wraps from 0x3F to 0x00.
- R4: A read returns the byte at the pointer, MSB first, and advances the pointer with the same wrap. It continues while the host acknowledges. After a host NACK, SDA stays released until the next START.
- R5: A write to 0x00–0x06 raises `tm_wr_o` for exactly one cycle, with `tm_idx_o` = address and `tm_data_o` = byte. The pulse comes one cycle after the SCL fall that ends the byte. Writes at 0x07–0x3F raise no pulse.
- R6: At every START and at every accepted pointer byte, `live_time_i` (byte i at bits [8i+7:8i]) is copied into the shadow. Reads of 0x00–0x06 return the shadow, and later changes of `live_time_i` stay invisible until the next copy.
- R7: Address 0x07 holds the control byte, which is shown on `ctrl_o`. Addresses 0x08–0x3F hold RAM bytes that read back what was last written.
- R8: While `acc_en_i` is low, the address byte is not acknowledged. A pointer or data byte that ends while it is low is not acknowledged and changes nothing.
- R9: START and STOP (an SDA fall or rise while SCL is high) are recognised in any state. A STOP releases SDA and idles the block. A START, even in mid-byte, restarts the address phase.
- R10: After reset, SDA is released, `ctrl_o` is 0x00, every RAM byte reads 0x00, and the pointer is 0x00.
- R11: The SDA drive enable rises only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock pin |
| sda_i | input | 1 | Raw bus data pin, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| acc_en_i | input | 1 | Main-supply access permission from power control |
| live_time_i | input | 56 | Live time bytes from the clock block, byte i at [8i+7:8i] |
| tm_wr_o | output | 1 | One-cycle write strobe to a time byte |
| tm_idx_o | output | 3 | Index of the time byte written |
| tm_data_o | output | 8 | Value written to the time byte |
| ctrl_o | output | 8 | Control byte at address 0x07 |

## Verification
A pointer that drifts or fails to wrap shows up on the next byte streamed out, so a full-space read after a full-space write exposes it within one byte time. A stale or wrongly refreshed shadow shows as time bytes that disagree with the clock model, either in the transaction that follows a change or in the one after it. A receive or transmit state that is one bit out of step moves the acknowledge slot, and the host sees the missing or misplaced ACK on the very next ninth clock. Gating errors on the access enable become visible at once, as an acknowledged address or a strobe raised while access is refused.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

    typedef enum logic [3:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_PTR,
        LK_PTR_ACK,
        LK_WDAT,
        LK_WDAT_ACK,
        LK_RDAT,
        LK_RACK
    } link_st_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned LINES = 2;
    localparam int unsigned CH_W  = STAGES + 1;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prv;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [CH_W-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CH_W-2:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign lvl[g] = chain_q[STAGES-1];
        assign prv[g] = chain_q[STAGES];
    end

    assign scl_lvl_o  = lvl[0];
    assign sda_lvl_o  = lvl[1];
    assign scl_rise_o = lvl[0] & ~prv[0];
    assign scl_fall_o = ~lvl[0] & prv[0];
    assign start_o    = lvl[0] & prv[0] & prv[1] & ~lvl[1];
    assign stop_o     = lvl[0] & prv[0] & ~prv[1] & lvl[1];

endmodule

// File: rtl/rtc_i2c_link.sv
module rtc_i2c_link
    import rtc_i2c_pkg::*;
#(
    parameter int unsigned PTR_W  = 6,
    parameter logic [6:0]  DEV_ID = 7'h68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_lvl_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             acc_en_i,
    input  logic [7:0]       rdata_i,
    output logic [PTR_W-1:0] raddr_o,
    output logic             snap_o,
    output logic             wr_o,
    output logic [PTR_W-1:0] waddr_o,
    output logic [7:0]       wdata_o,
    output logic             sda_oe_o
);
    localparam logic [3:0]       BITS_IN  = 4'd8;
    localparam logic [3:0]       BITS_OUT = 4'd7;
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    typedef struct packed {
        link_st_e         st;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [7:0]       tx;
        logic [PTR_W-1:0] ptr;
        logic             rw;
        logic             mack;
        logic             oe;
        logic             snap;
        logic             wr;
        logic [PTR_W-1:0] waddr;
        logic [7:0]       wdata;
    } link_t;

    localparam link_t LINK_RST = '{
        st: LK_IDLE, cnt: '0, sh: '0, tx: '0, ptr: '0, rw: 1'b0,
        mack: 1'b0, oe: 1'b0, snap: 1'b0, wr: 1'b0, waddr: '0, wdata: '0
    };

    link_t lk_d, lk_q;

    always_comb begin
        lk_d      = lk_q;
        lk_d.snap = 1'b0;
        lk_d.wr   = 1'b0;
        if (start_i) begin
            lk_d.st   = LK_ADDR;
            lk_d.cnt  = '0;
            lk_d.oe   = 1'b0;
            lk_d.snap = 1'b1;
        end else if (stop_i) begin
            lk_d.st = LK_IDLE;
            lk_d.oe = 1'b0;
        end else begin
            unique case (lk_q.st)
                LK_ADDR, LK_PTR, LK_WDAT: begin
                    if (scl_rise_i && lk_q.cnt < BITS_IN) begin
                        lk_d.sh  = {lk_q.sh[6:0], sda_lvl_i};
                        lk_d.cnt = lk_q.cnt + 4'd1;
                    end else if (scl_fall_i && lk_q.cnt == BITS_IN) begin
                        lk_d.cnt = '0;
                        lk_d.st  = LK_IDLE;
                        if (acc_en_i) begin
                            if (lk_q.st == LK_ADDR) begin
                                if (lk_q.sh[7:1] == DEV_ID) begin
                                    lk_d.rw = lk_q.sh[0];
                                    lk_d.oe = 1'b1;
                                    lk_d.st = LK_ADDR_ACK;
                                end
                            end else if (lk_q.st == LK_PTR) begin
                                lk_d.ptr  = lk_q.sh[PTR_W-1:0];
                                lk_d.snap = 1'b1;
                                lk_d.oe   = 1'b1;
                                lk_d.st   = LK_PTR_ACK;
                            end else begin
                                lk_d.wr    = 1'b1;
                                lk_d.waddr = lk_q.ptr;
                                lk_d.wdata = lk_q.sh;
                                lk_d.ptr   = lk_q.ptr + PTR_ONE;
                                lk_d.oe    = 1'b1;
                                lk_d.st    = LK_WDAT_ACK;
                            end
                        end
                    end
                end
                LK_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        lk_d.cnt = '0;
                        if (lk_q.rw) begin
                            lk_d.tx  = rdata_i;
                            lk_d.ptr = lk_q.ptr + PTR_ONE;
                            lk_d.oe  = ~rdata_i[7];
                            lk_d.st  = LK_RDAT;
                        end else begin
                            lk_d.oe = 1'b0;
                            lk_d.st = LK_PTR;
                        end
                    end
                end
                LK_PTR_ACK, LK_WDAT_ACK: begin
                    if (scl_fall_i) begin
                        lk_d.oe  = 1'b0;
                        lk_d.cnt = '0;
                        lk_d.st  = LK_WDAT;
                    end
                end
                LK_RDAT: begin
                    if (scl_fall_i) begin
                        if (lk_q.cnt == BITS_OUT) begin
                            lk_d.oe  = 1'b0;
                            lk_d.cnt = '0;
                            lk_d.st  = LK_RACK;
                        end else begin
                            lk_d.tx  = {lk_q.tx[6:0], 1'b0};
                            lk_d.cnt = lk_q.cnt + 4'd1;
                            lk_d.oe  = ~lk_q.tx[6];
                        end
                    end
                end
                LK_RACK: begin
                    if (scl_rise_i) begin
                        lk_d.mack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (lk_q.mack && acc_en_i) begin
                            lk_d.tx  = rdata_i;
                            lk_d.ptr = lk_q.ptr + PTR_ONE;
                            lk_d.oe  = ~rdata_i[7];
                            lk_d.cnt = '0;
                            lk_d.st  = LK_RDAT;
                        end else begin
                            lk_d.oe = 1'b0;
                            lk_d.st = LK_IDLE;
                        end
                    end
                end
                default: begin
                    lk_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LINK_RST;
        else        lk_q <= lk_d;
    end

    assign raddr_o  = lk_q.ptr;
    assign snap_o   = lk_q.snap;
    assign wr_o     = lk_q.wr;
    assign waddr_o  = lk_q.waddr;
    assign wdata_o  = lk_q.wdata;
    assign sda_oe_o = lk_q.oe;

endmodule

// File: rtl/rtc_i2c_store.sv
module rtc_i2c_store #(
    parameter int unsigned PTR_W = 6,
    parameter int unsigned TB    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     snap_i,
    input  logic [TB*8-1:0]          live_i,
    input  logic                     wr_i,
    input  logic [PTR_W-1:0]         waddr_i,
    input  logic [7:0]               wdata_i,
    input  logic [PTR_W-1:0]         raddr_i,
    output logic [7:0]               rdata_o,
    output logic                     tm_wr_o,
    output logic [$clog2(TB)-1:0]    tm_idx_o,
    output logic [7:0]               tm_data_o,
    output logic [7:0]               ctrl_o
);
    localparam int unsigned      SPACE = 2 ** PTR_W;
    localparam int unsigned      RD    = SPACE - TB;
    localparam int unsigned      TIW   = $clog2(TB);
    localparam int unsigned      RIW   = $clog2(RD);
    localparam logic [PTR_W-1:0] TB_P  = PTR_W'(TB);

    typedef struct packed {
        logic [TB-1:0][7:0] shadow;
        logic [RD-1:0][7:0] ram;
    } store_t;

    store_t st_d, st_q;

    logic [PTR_W-1:0] w_off, r_off;
    logic             w_time, r_time;

    assign w_off  = waddr_i - TB_P;
    assign r_off  = raddr_i - TB_P;
    assign w_time = waddr_i < TB_P;
    assign r_time = raddr_i < TB_P;

    always_comb begin
        st_d = st_q;
        if (snap_i) begin
            for (int i = 0; i < TB; i++) begin
                st_d.shadow[i] = live_i[i*8 +: 8];
            end
        end
        if (wr_i && !w_time) begin
            st_d.ram[RIW'(w_off)] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (r_time) rdata_o = st_q.shadow[TIW'(raddr_i)];
        else        rdata_o = st_q.ram[RIW'(r_off)];
    end

    assign tm_wr_o   = wr_i && w_time;
    assign tm_idx_o  = TIW'(waddr_i);
    assign tm_data_o = wdata_i;
    assign ctrl_o    = st_q.ram[0];

endmodule

// File: rtl/rtc_i2c_regfile.sv
module rtc_i2c_regfile #(
    parameter int unsigned PTR_W       = 6,
    parameter int unsigned TIME_BYTES  = 7,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ID      = 7'h68
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe_o,
    input  logic                          acc_en_i,
    input  logic [TIME_BYTES*8-1:0]       live_time_i,
    output logic                          tm_wr_o,
    output logic [$clog2(TIME_BYTES)-1:0] tm_idx_o,
    output logic [7:0]                    tm_data_o,
    output logic [7:0]                    ctrl_o
);
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic             snap, wr;
    logic [PTR_W-1:0] waddr, raddr;
    logic [7:0]       wdata, rdata;

    rtc_i2c_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    rtc_i2c_link #(
        .PTR_W  (PTR_W),
        .DEV_ID (DEV_ID)
    ) i_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl_i  (sda_lvl),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .acc_en_i   (acc_en_i),
        .rdata_i    (rdata),
        .raddr_o    (raddr),
        .snap_o     (snap),
        .wr_o       (wr),
        .waddr_o    (waddr),
        .wdata_o    (wdata),
        .sda_oe_o   (sda_oe_o)
    );

    rtc_i2c_store #(
        .PTR_W (PTR_W),
        .TB    (TIME_BYTES)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_i    (snap),
        .live_i    (live_time_i),
        .wr_i      (wr),
        .waddr_i   (waddr),
        .wdata_i   (wdata),
        .raddr_i   (raddr),
        .rdata_o   (rdata),
        .tm_wr_o   (tm_wr_o),
        .tm_idx_o  (tm_idx_o),
        .tm_data_o (tm_data_o),
        .ctrl_o    (ctrl_o)
    );

endmodule

// File: rtl/rtc_i2c_regfile_chk.sv
module rtc_i2c_regfile_chk #(
    parameter int unsigned TB = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_en_i,
    input logic                  sda_oe_o,
    input logic                  tm_wr_o,
    input logic [$clog2(TB)-1:0] tm_idx_o,
    input logic                  scl_lvl,
    input logic                  stop_ev
);
    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tm_wr_o |=> !tm_wr_o);

    assert_wr_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tm_wr_o |-> (32'(tm_idx_o) < TB));

    assert_wr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tm_wr_o |-> $past(acc_en_i));

    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o);

endmodule

bind rtc_i2c_regfile rtc_i2c_regfile_chk #(
    .TB (TIME_BYTES)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en_i (acc_en_i),
    .sda_oe_o (sda_oe_o),
    .tm_wr_o  (tm_wr_o),
    .tm_idx_o (tm_idx_o),
    .scl_lvl  (scl_lvl),
    .stop_ev  (stop_ev)
);

// File: tb/test_rtc_i2c_regfile.sv
module test_rtc_i2c_regfile;
    localparam int Q = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       acc_en = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] live [7];
    logic [55:0] live_flat;
    logic       tm_wr;
    logic [2:0] tm_idx;
    logic [7:0] tm_data;
    logic [7:0] ctrl;
    logic       poke = 1'b0;
    logic [2:0] poke_idx = '0;
    logic [7:0] poke_val = '0;
    logic       oe_prev;
    int         wr_pulses;
    int         oe_bad;
    int         n_chk = 0;
    int         n_err = 0;

    assign sda_line = sda_m & ~sda_oe;

    always_comb begin
        for (int i = 0; i < 7; i++) live_flat[i*8 +: 8] = live[i];
    end

    rtc_i2c_regfile i_rtc_i2c_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .acc_en_i    (acc_en),
        .live_time_i (live_flat),
        .tm_wr_o     (tm_wr),
        .tm_idx_o    (tm_idx),
        .tm_data_o   (tm_data),
        .ctrl_o      (ctrl)
    );

    // clock-block model plus drive monitor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) live[i] <= 8'h10 + 8'(i);
            wr_pulses <= 0;
            oe_bad    <= 0;
            oe_prev   <= 1'b0;
        end else begin
            if (tm_wr) begin
                live[tm_idx] <= tm_data;
                wr_pulses    <= wr_pulses + 1;
            end else if (poke) begin
                live[poke_idx] <= poke_val;
            end
            oe_prev <= sda_oe;
            if (sda_oe && !oe_prev && scl_m) oe_bad <= oe_bad + 1;
        end
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; qw(); scl_m = 1'b1; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; qw(); scl_m = 1'b1;
        repeat (Q / 2) @(negedge clk);
        b = sda_line;
        repeat (Q / 2) @(negedge clk);
        scl_m = 1'b0; qw();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic last);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(last);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        i2c_start();
        wbyte(8'hD0, a);
        wbyte(p, a);
    endtask

    task automatic read_at(input logic [7:0] p, output logic [7:0] d);
        logic a;
        set_ptr(p);
        i2c_start();
        wbyte(8'hD1, a);
        rbyte(d, 1'b1);
        i2c_stop();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic       a;
        logic       b;
        logic [7:0] d;
        logic [8:0] rest;
        int         p0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 reset state
        chk("R10 sda released", 32'(sda_oe), 32'd0);
        chk("R10 ctrl", 32'(ctrl), 32'd0);
        read_at(8'h08, d);
        chk("R10 ram zero", 32'(d), 32'd0);
        read_at(8'h3F, d);
        chk("R10 ram top zero", 32'(d), 32'd0);

        // R1 address sweep
        for (int ad = 0; ad < 128; ad++) begin
            i2c_start();
            wbyte({7'(ad), 1'b0}, a);
            i2c_stop();
            chk("R1 address ack", 32'(a), 32'(ad == 'h68));
        end
        i2c_start();
        wbyte(8'hD1, a);
        chk("R1 read address ack", 32'(a), 32'd1);
        rbyte(d, 1'b1);
        i2c_stop();

        // R3 / R7 / R5 full write sweep with wrap
        p0 = wr_pulses;
        set_ptr(8'h07);
        for (int ad = 7; ad < 64; ad++) begin
            wbyte(pat(ad), a);
            chk("R3 data ack", 32'(a), 32'd1);
        end
        wbyte(8'hA0, a);
        wbyte(8'hA1, a);
        i2c_stop();
        chk("R7 control byte", 32'(ctrl), 32'(pat(7)));
        chk("R3 wrap to time byte 0", 32'(live[0]), 32'hA0);
        chk("R3 wrap to time byte 1", 32'(live[1]), 32'hA1);
        chk("R5 only time writes strobe", 32'(wr_pulses - p0), 32'd2);

        // R4 / R7 read-back
        set_ptr(8'h07);
        i2c_start();
        wbyte(8'hD1, a);
        for (int ad = 7; ad < 64; ad++) begin
            rbyte(d, 1'(ad == 63));
            chk("R4 read stream", 32'(d), 32'(pat(ad)));
        end
        i2c_stop();

        // R4 read wrap, R9 repeated start
        set_ptr(8'h3E);
        i2c_start();
        wbyte(8'hD1, a);
        rbyte(d, 1'b0); chk("R9 read after restart", 32'(d), 32'(pat(62)));
        rbyte(d, 1'b0); chk("R4 top byte", 32'(d), 32'(pat(63)));
        rbyte(d, 1'b0); chk("R4 wrap byte 0", 32'(d), 32'hA0);
        rbyte(d, 1'b1); chk("R4 wrap byte 1", 32'(d), 32'hA1);
        i2c_stop();
        chk("R9 released after stop", 32'(sda_oe), 32'd0);

        // R2 upper pointer bits ignored
        read_at(8'hC9, d);
        chk("R2 pointer low bits", 32'(d), 32'(pat(9)));
        read_at(8'h80, d);
        chk("R2 pointer 0x80 to 0x00", 32'(d), 32'hA0);

        // R6 shadow coherency
        set_ptr(8'h02);
        i2c_stop();
        i2c_start();
        wbyte(8'hD1, a);
        rbyte(d, 1'b0);
        chk("R6 shadow byte 2", 32'(d), 32'h12);
        @(negedge clk); poke_idx = 3'd3; poke_val = 8'h77; poke = 1'b1;
        @(negedge clk); poke = 1'b0;
        rbyte(d, 1'b1);
        chk("R6 old value kept", 32'(d), 32'h13);
        i2c_stop();
        read_at(8'h03, d);
        chk("R6 new value after snapshot", 32'(d), 32'h77);

        // R5 time write strobe
        p0 = wr_pulses;
        set_ptr(8'h04);
        wbyte(8'h45, a);
        i2c_stop();
        chk("R5 time byte written", 32'(live[4]), 32'h45);
        chk("R5 single strobe", 32'(wr_pulses - p0), 32'd1);

        // R8 access refused
        acc_en = 1'b0;
        i2c_start();
        wbyte(8'hD0, a);
        i2c_stop();
        chk("R8 address refused", 32'(a), 32'd0);
        acc_en = 1'b1;
        p0 = wr_pulses;
        set_ptr(8'h20);
        acc_en = 1'b0;
        wbyte(8'h5A, a);
        i2c_stop();
        chk("R8 data refused", 32'(a), 32'd0);
        acc_en = 1'b1;
        read_at(8'h20, d);
        chk("R8 ram unchanged", 32'(d), 32'(pat(32)));
        set_ptr(8'h05);
        acc_en = 1'b0;
        wbyte(8'h99, a);
        i2c_stop();
        acc_en = 1'b1;
        chk("R8 time unchanged", 32'(live[5]), 32'h15);
        chk("R8 no strobe", 32'(wr_pulses - p0), 32'd0);

        // R4 release after host NACK
        set_ptr(8'h10);
        i2c_start();
        wbyte(8'hD1, a);
        rbyte(d, 1'b1);
        chk("R4 read before nack", 32'(d), 32'(pat(16)));
        for (int i = 0; i < 9; i++) begin
            rbit(b);
            rest[i] = b;
        end
        chk("R4 released after nack", 32'(rest), 32'h1FF);
        i2c_stop();

        // R9 start in mid-byte
        i2c_start();
        wbit(1'b1); wbit(1'b1); wbit(1'b0);
        i2c_start();
        wbyte(8'hD0, a);
        chk("R9 restart mid-byte", 32'(a), 32'd1);
        wbyte(8'h3A, a);
        wbyte(8'h6C, a);
        i2c_stop();
        read_at(8'h3A, d);
        chk("R9 write after restart", 32'(d), 32'h6C);

        // R11 drive timing seen at the pin
        chk("R11 drive only with scl low", 32'(oe_bad), 32'd0);

        finish_run();
    end

endmodule